// File: doc/BRIEF.md
# MIDI Port Host Register Model (UART Mode)

This block is the host-facing register model of a MIDI port compatible with the classic intelligent-interface command set, limited to its pass-through UART mode. The host sees two byte locations. Offset 0 is the data location: writes queue an outgoing MIDI byte, and reads take the next incoming byte. Offset 1 takes command bytes when written and returns a status byte when read. Two flags in the status byte are active low. One reports that an incoming byte is waiting. The other reports that the data location can take a byte.

Outgoing bytes enter a transmit FIFO whose head is offered to an external serialiser through a valid/take handshake. Incoming bytes arrive from an external MIDI receiver through a valid/ready handshake and enter a receive FIFO. The acknowledge byte produced by an accepted command travels through the same receive FIFO. Only two commands have any effect: the port reset and the switch into UART mode. Two one-cycle interrupt strobes mark the transmit FIFO draining and the receive FIFO gaining data.

Top module: `midi_uart_port`

## Requirements
- R1: A read at offset 1 returns a status byte, one cycle later on `bus_rdata`. Bit 7 is 0 exactly when the receive FIFO holds a byte. Bit 6 is 0 exactly when the transmit FIFO is not full. Bits 5..0 are 0.
- R2: Command byte 0xFF, written at offset 1 in either mode, returns the port to non-UART mode and empties both FIFOs. The receive FIFO then holds only the acknowledge byte 0xFE.
- R3: Command byte 0x3F written outside UART mode switches the port to UART mode and queues the acknowledge byte 0xFE in the receive FIFO.
- R4: Any other command byte, and 0x3F written while already in UART mode, changes no mode and queues no acknowledge.
- R5: Outside UART mode, data-location writes are discarded (`tx_valid` stays low) and `rx_ready` is low.
- R6: In UART mode, data-location writes enter the transmit FIFO in order. `tx_byte` shows the head whenever `tx_valid` is high, and `tx_take` removes it. A write to a full transmit FIFO is discarded.
- R7: In UART mode, `rx_ready` is high when the receive FIFO is not full and no command write is in progress in the same cycle. A byte offered with `rx_valid` while `rx_ready` is high is stored. Data-location reads return stored bytes in arrival order, one cycle after the read.
- R8: A data-location read while the receive FIFO is empty returns the most recently removed byte. It removes nothing, and later bytes are still delivered correctly.
- R9: `irq_tx_empty` pulses high for exactly one cycle, one cycle after the transmit FIFO becomes empty.
- R10: `irq_rx_data` pulses high for exactly one cycle, one cycle after the receive FIFO goes from empty to holding data.
- R11: After `rst`, the port is in non-UART mode, both FIFOs are empty, the status byte reads 0x80, both interrupt strobes are low and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Location select: 0 data, 1 command/status |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Registered host read byte |
| tx_byte | output | 8 | Head of the transmit FIFO |
| tx_valid | output | 1 | Transmit FIFO holds a byte |
| tx_take | input | 1 | Serialiser removes the head byte |
| rx_byte | input | 8 | Byte from the MIDI receiver |
| rx_valid | input | 1 | Receiver offers `rx_byte` |
| rx_ready | output | 1 | Port can store the offered byte |
| irq_tx_empty | output | 1 | One-cycle strobe when the transmit FIFO drains |
| irq_rx_data | output | 1 | One-cycle strobe when received data becomes available |

## Verification
The assertions assume that the host never raises `bus_wr` and `bus_rd` in the same cycle, and that the serialiser asserts `tx_take` only while `tx_valid` is high. Each bench task drives one host access at a time, clearing the strobe after the capturing edge. It raises `tx_take` only after it has checked that a byte is present. Receiver offers are timed against `rx_ready`. A single deliberate overlap of a receiver offer with a command write exercises the refusal rule.

// File: rtl/midi_pkg.sv
package midi_pkg;
  localparam logic [7:0] CMD_PORT_RESET = 8'hFF;
  localparam logic [7:0] CMD_UART_ENTER = 8'h3F;
  localparam logic [7:0] ACK_BYTE       = 8'hFE;
  localparam int unsigned BYTE_W        = 8;

  typedef struct packed {
    logic       rx_none;   // bit 7, 0 = byte waiting
    logic       tx_busy;   // bit 6, 0 = can accept
    logic [5:0] zero;
  } status_t;
endpackage

// File: rtl/mpu_byte_fifo.sv
module mpu_byte_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          wr_en, rd_en;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign wr_en = push && (flush || !full);
  assign rd_en = pop && !empty && !flush;
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= wr_ptr;
      wr_ptr <= wr_en ? step(wr_ptr) : wr_ptr;
      count  <= CW'(wr_en);
    end else begin
      if (wr_en) wr_ptr <= step(wr_ptr);
      if (rd_en) rd_ptr <= step(rd_ptr);
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end
endmodule

// File: rtl/mpu_mode_ctrl.sv
module mpu_mode_ctrl
  import midi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              uart_mode,
  output logic              flush,
  output logic              ack_push
);
  logic is_reset, is_enter;

  assign is_reset = cmd_wr && (cmd_byte == CMD_PORT_RESET);
  assign is_enter = cmd_wr && (cmd_byte == CMD_UART_ENTER) && !uart_mode;
  assign flush    = is_reset;
  assign ack_push = is_reset || is_enter;

  always_ff @(posedge clk) begin
    if (rst)           uart_mode <= 1'b0;
    else if (is_reset) uart_mode <= 1'b0;
    else if (is_enter) uart_mode <= 1'b1;
  end
endmodule

// File: rtl/mpu_irq_edge.sv
module mpu_irq_edge #(
  parameter bit RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= RST_LEVEL;
      pulse <= 1'b0;
    end else begin
      prev  <= level;
      pulse <= level && !prev;
    end
  end
endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port
  import midi_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [7:0] tx_byte,
  output logic       tx_valid,
  input  logic       tx_take,
  input  logic [7:0] rx_byte,
  input  logic       rx_valid,
  output logic       rx_ready,
  output logic       irq_tx_empty,
  output logic       irq_rx_data
);
  logic              cmd_wr, data_wr, data_rd;
  logic              uart_mode, flush, ack_push;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              rx_push;
  logic [BYTE_W-1:0] rx_din, rx_head, last_byte;
  status_t           status;

  assign cmd_wr  = bus_wr && bus_sel;
  assign data_wr = bus_wr && !bus_sel;
  assign data_rd = bus_rd && !bus_sel;

  mpu_mode_ctrl u_mode (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .cmd_byte (bus_wdata),
    .uart_mode(uart_mode),
    .flush    (flush),
    .ack_push (ack_push)
  );

  mpu_byte_fifo #(.DEPTH(TX_DEPTH), .W(BYTE_W)) u_txq (
    .clk  (clk),
    .rst  (rst),
    .flush(flush),
    .push (data_wr && uart_mode),
    .din  (bus_wdata),
    .pop  (tx_take),
    .head (tx_byte),
    .empty(tx_empty),
    .full (tx_full)
  );

  assign tx_valid = !tx_empty;

  // Receiver is refused during a command write so the acknowledge owns the write port.
  assign rx_ready = uart_mode && !rx_full && !cmd_wr;
  assign rx_push  = ack_push || (rx_valid && rx_ready);
  assign rx_din   = ack_push ? ACK_BYTE : rx_byte;

  mpu_byte_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rxq (
    .clk  (clk),
    .rst  (rst),
    .flush(flush),
    .push (rx_push),
    .din  (rx_din),
    .pop  (data_rd),
    .head (rx_head),
    .empty(rx_empty),
    .full (rx_full)
  );

  assign status = '{rx_none: rx_empty, tx_busy: tx_full, zero: '0};

  always_ff @(posedge clk) begin
    if (rst) begin
      last_byte <= '0;
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_sel) begin
        bus_rdata <= status;
      end else if (rx_empty) begin
        bus_rdata <= last_byte;
      end else begin
        bus_rdata <= rx_head;
        last_byte <= rx_head;
      end
    end
  end

  mpu_irq_edge #(.RST_LEVEL(1'b1)) u_irq_tx (
    .clk  (clk),
    .rst  (rst),
    .level(tx_empty),
    .pulse(irq_tx_empty)
  );

  mpu_irq_edge #(.RST_LEVEL(1'b0)) u_irq_rx (
    .clk  (clk),
    .rst  (rst),
    .level(!rx_empty),
    .pulse(irq_rx_data)
  );
endmodule

// File: rtl/midi_uart_port_chk.sv
module midi_uart_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       tx_valid,
  input logic       irq_tx_empty,
  input logic       irq_rx_data,
  input logic       uart_mode,
  input logic       rx_empty
);
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel) |=> (bus_rdata[5:0] == 6'd0)); // R1
  AST_RESET_CMD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel && bus_wdata == 8'hFF) |=> (!uart_mode && !tx_valid && !rx_empty)); // R2
  AST_ENTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel && bus_wdata == 8'h3F && !uart_mode) |=> (uart_mode && !rx_empty)); // R3
  AST_OTHER_CMD_MODE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel && bus_wdata != 8'hFF && bus_wdata != 8'h3F) |=> $stable(uart_mode)); // R4
  AST_IDLE_NO_TX: assert property (@(posedge clk) disable iff (rst)
    !uart_mode |-> !tx_valid); // R5
  AST_IRQ_TX_ONE: assert property (@(posedge clk) disable iff (rst)
    irq_tx_empty |=> !irq_tx_empty); // R9
  AST_IRQ_RX_ONE: assert property (@(posedge clk) disable iff (rst)
    irq_rx_data |=> !irq_rx_data); // R10
endmodule

bind midi_uart_port midi_uart_port_chk u_chk (.*);

// File: tb/sim_midi_uart_port.sv
module sim_midi_uart_port;
  localparam int TXD = 8;
  localparam int RXD = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] tx_byte;
  logic       tx_valid, tx_take = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_valid = 1'b0, rx_ready;
  logic       irq_tx_empty, irq_rx_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  midi_uart_port u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d);
    @(negedge clk); bus_sel = sel; bus_rd = 1'b1;
    @(posedge clk); #1 bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b, input bit exp_ready, input string req);
    @(negedge clk); rx_byte = b; rx_valid = 1'b1; #1;
    check(rx_ready == exp_ready, req, rx_ready, exp_ready);
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  task automatic expect_status(input logic [7:0] e, input string req);
    logic [7:0] d;
    bus_read(1'b1, d);
    check(d == e, req, d, e);
  endtask

  task automatic expect_data(input logic [7:0] e, input string req);
    logic [7:0] d;
    bus_read(1'b0, d);
    check(d == e, req, d, e);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(bus_rdata == 8'h00, "R11 rdata after reset", bus_rdata, 0);
    check(!tx_valid && !rx_ready, "R11 handshakes idle", {tx_valid, rx_ready}, 0);
    check(!irq_tx_empty && !irq_rx_data, "R11 strobes low", {irq_tx_empty, irq_rx_data}, 0);
    expect_status(8'h80, "R11 status after reset");
  endtask

  task automatic t_idle_discard;
    bus_write(1'b0, 8'h55);
    @(negedge clk);
    check(!tx_valid, "R5 data write ignored outside UART", tx_valid, 0);
    check(!rx_ready, "R5 receiver refused outside UART", rx_ready, 0);
  endtask

  task automatic t_other_cmd;
    bus_write(1'b1, 8'h12);
    bus_write(1'b1, 8'h00);
    expect_status(8'h80, "R4 unknown command queues no ack");
    @(negedge clk);
    check(!rx_ready, "R4 unknown command keeps non-UART", rx_ready, 0);
  endtask

  task automatic t_enter;
    bus_write(1'b1, 8'h3F);
    check(!irq_rx_data, "R10 no strobe before pulse cycle", irq_rx_data, 0);
    @(posedge clk); #1;
    check(irq_rx_data, "R10 strobe on ack arrival", irq_rx_data, 1);
    @(posedge clk); #1;
    check(!irq_rx_data, "R10 strobe lasts one cycle", irq_rx_data, 0);
    check(rx_ready, "R3 UART mode entered", rx_ready, 1);
    expect_status(8'h00, "R1 status with byte waiting");
    expect_data(8'hFE, "R3 ack byte");
    expect_status(8'h80, "R1 status after ack read");
  endtask

  task automatic t_uart_cmd_ignored;
    bus_write(1'b1, 8'h3F);
    bus_write(1'b1, 8'h01);
    expect_status(8'h80, "R4 repeat enter and unknown give no ack");
    @(negedge clk);
    check(rx_ready, "R4 mode kept", rx_ready, 1);
  endtask

  task automatic t_tx_path;
    logic [7:0] exp [3] = '{8'hA1, 8'hB2, 8'hC3};
    for (int i = 0; i < 3; i++) bus_write(1'b0, exp[i]);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(tx_valid && tx_byte == exp[i], "R6 transmit order", tx_byte, exp[i]);
      tx_take = 1'b1;
      @(posedge clk); #1 tx_take = 1'b0;
    end
    check(!tx_valid, "R6 transmit drained", tx_valid, 0);
    check(!irq_tx_empty, "R9 strobe not yet", irq_tx_empty, 0);
    @(posedge clk); #1;
    check(irq_tx_empty, "R9 strobe on drain", irq_tx_empty, 1);
    @(posedge clk); #1;
    check(!irq_tx_empty, "R9 strobe one cycle", irq_tx_empty, 0);
  endtask

  task automatic t_tx_full;
    for (int i = 0; i < TXD + 2; i++) bus_write(1'b0, 8'(8'h10 + i));
    expect_status(8'hC0, "R1 status with transmit full");
    for (int i = 0; i < TXD; i++) begin
      @(negedge clk);
      check(tx_valid && tx_byte == 8'(8'h10 + i), "R6 full-FIFO content", tx_byte, 8'h10 + i);
      tx_take = 1'b1;
      @(posedge clk); #1 tx_take = 1'b0;
    end
    check(!tx_valid, "R6 writes beyond full dropped", tx_valid, 0);
  endtask

  task automatic t_rx_path;
    rx_push(8'h90, 1'b1, "R7 ready in UART");
    rx_push(8'h3C, 1'b1, "R7 ready in UART");
    rx_push(8'h7F, 1'b1, "R7 ready in UART");
    expect_data(8'h90, "R7 receive order 0");
    expect_data(8'h3C, "R7 receive order 1");
    expect_data(8'h7F, "R7 receive order 2");
  endtask

  task automatic t_rx_underflow;
    expect_data(8'h7F, "R8 empty read repeats last");
    expect_data(8'h7F, "R8 second empty read");
    expect_status(8'h80, "R8 no underflow");
    rx_push(8'h11, 1'b1, "R8 push after empty reads");
    expect_data(8'h11, "R8 delivery after empty reads");
  endtask

  task automatic t_rx_full;
    for (int i = 0; i < RXD + 2; i++) rx_push(8'(8'h40 + i), i < RXD, "R7 ready tracks fullness");
    for (int i = 0; i < RXD; i++) expect_data(8'(8'h40 + i), "R7 full-FIFO content");
    expect_status(8'h80, "R7 overflow offers not stored");
  endtask

  task automatic t_cmd_blocks_rx;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h01;
    rx_byte = 8'h66; rx_valid = 1'b1; #1;
    check(!rx_ready, "R7 ready low during command write", rx_ready, 0);
    @(posedge clk); #1 bus_wr = 1'b0; rx_valid = 1'b0;
    expect_status(8'h80, "R7 refused byte not stored");
  endtask

  task automatic t_reset_cmd;
    bus_write(1'b0, 8'h20);
    bus_write(1'b0, 8'h21);
    rx_push(8'h30, 1'b1, "R2 setup");
    rx_push(8'h31, 1'b1, "R2 setup");
    bus_write(1'b1, 8'hFF);
    check(!tx_valid, "R2 transmit flushed", tx_valid, 0);
    check(!rx_ready, "R2 back to non-UART", rx_ready, 0);
    expect_data(8'hFE, "R2 only ack remains");
    expect_status(8'h80, "R2 receive holds nothing else");
    bus_write(1'b0, 8'h33);
    @(negedge clk);
    check(!tx_valid, "R5 discard after port reset", tx_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_idle_discard();
    t_other_cmd();
    t_enter();
    t_uart_cmd_ignored();
    t_tx_path();
    t_tx_full();
    t_rx_path();
    t_rx_underflow();
    t_rx_full();
    t_cmd_blocks_rx();
    t_reset_cmd();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule